// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers the interrupt sources of a multi-stream audio controller into one 32-bit global interrupt status word and a single level-sensitive interrupt line. Each stream reports a buffer-completion flag, the response ring reports a response-interrupt flag and an overrun flag, and each attached codec can report a state change. Those inputs are folded into a layered summary: one bit per stream, one controller bit and one global bit that is set whenever any lower bit is set.

The block also owns the 15-bit codec state-change register. A codec pulses its wake line to set the bit at its address; software clears bits by writing ones to them. A state-change bit only reaches the controller bit when its wake-enable bit is set. The interrupt line follows the status word gated by the interrupt control word: a global enable bit plus one enable per source position. The summary bit itself never raises the line. The line is registered, so it only moves on clock edges, and it stays low while reset is asserted.

Top module: `audio_irq_agg`

## Requirements
- R1: Status bit i (0 to NUM_STREAMS-1) of `intSts` equals `streamDone[i]` in the same cycle.
- R2: Status bit 30 (controller bit) of `intSts` is 1 whenever `respIntFlag` or `respOverrun` is 1.
- R3: Status bit 30 is also 1 whenever `stateChg & wakeEnable` is nonzero. A state-change bit whose wake-enable bit is 0 does not set bit 30.
- R4: Status bit 31 (global summary) is 1 exactly when any of bits 30..0 is 1.
- R5: At each rising clock edge `irq` loads `intCtl[31] & |(intSts[30:0] & intCtl[30:0])`. Bit 31 of `intCtl` is the global enable. Bit 31 of `intSts` never raises `irq` on its own.
- R6: A 1 on `codecWake[a]` sets `stateChg[a]` at the next rising edge.
- R7: A cycle with `stsWrEn` high clears, at the next edge, each `stateChg` bit whose `stsWrData` bit is 1. Bits written as 0 keep their value.
- R8: When the same bit is both woken and cleared in one cycle, the set wins and the bit reads 1 afterwards.
- R9: While `rstN` is low, `stateChg` is 0 and `irq` is 0, whatever the inputs.
- R10: Status bits NUM_STREAMS to 29 of `intSts` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| streamDone | input | NUM_STREAMS | Per-stream buffer-completion status |
| respIntFlag | input | 1 | Response-ring interrupt flag |
| respOverrun | input | 1 | Response-ring overrun flag |
| codecWake | input | 15 | Per-codec state-change set pulses |
| wakeEnable | input | 15 | Wake-enable mask for state-change bits |
| stsWrEn | input | 1 | Write strobe for the state-change register |
| stsWrData | input | 15 | Write data; ones clear bits |
| intCtl | input | 32 | Interrupt control: bit 31 global enable, bits 30..0 source enables |
| stateChg | output | 15 | Codec state-change register |
| intSts | output | 32 | Global interrupt status word |
| irq | output | 1 | Registered interrupt line |

## Verification
The two functions that can meet in one cycle are a codec wake and a software clear of the state-change register. When they hit the same bit, the set must win. The random phase drives wake pulses and clear writes with overlapping masks in the same cycle. Directed steps force an exact collision on one address, with a neighbouring bit cleared alone. After each edge the bench compares `stateChg`, and the controller and summary bits that depend on it, against a model that applies the clear first and the set second.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int CODEC_CNT  = 15;
  localparam int STS_W      = 32;
  localparam int CTRL_BIT   = 30;
  localparam int GLOBAL_BIT = 31;

  // strobes from control to datapath
  typedef struct packed {
    logic [CODEC_CNT-1:0] setMask;
    logic [CODEC_CNT-1:0] clrMask;
    logic                 globalEn;
  } irqStrobes_t;
endpackage

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
(
  input  logic [CODEC_CNT-1:0] codecWake,
  input  logic                 stsWrEn,
  input  logic [CODEC_CNT-1:0] stsWrData,
  input  logic                 globalEnIn,
  output irqStrobes_t          strb
);
  always_comb begin
    strb.setMask  = codecWake;
    // a wake in the same cycle wins over a clear of that bit
    strb.clrMask  = stsWrEn ? (stsWrData & ~codecWake) : '0;
    strb.globalEn = globalEnIn;
  end
endmodule

// File: rtl/audio_irq_datapath.sv
module audio_irq_datapath
  import audio_irq_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  irqStrobes_t            strb,
  input  logic [NUM_STREAMS-1:0] streamDone,
  input  logic                   respIntFlag,
  input  logic                   respOverrun,
  input  logic [CODEC_CNT-1:0]   wakeEnable,
  input  logic [STS_W-2:0]       sourceEn,
  output logic [CODEC_CNT-1:0]   stateChg,
  output logic [STS_W-1:0]       intSts,
  output logic                   irq
);
  localparam int LOW_W = STS_W - 1;

  logic [LOW_W-1:0] stsLow;
  logic             ctrlHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateChg <= '0;
    else       stateChg <= (stateChg & ~strb.clrMask) | strb.setMask;
  end

  assign ctrlHit = respIntFlag | respOverrun | (|(stateChg & wakeEnable));

  genvar g;
  generate
    for (g = 0; g < CTRL_BIT; g++) begin : g_bit
      if (g < NUM_STREAMS) begin : g_stream
        assign stsLow[g] = streamDone[g];
      end else begin : g_unused
        assign stsLow[g] = 1'b0;
      end
    end
  endgenerate
  assign stsLow[CTRL_BIT] = ctrlHit;

  assign intSts = {|stsLow, stsLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= strb.globalEn & (|(stsLow & sourceEn));
  end

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setMask) |=> ((stateChg & $past(strb.setMask)) == $past(strb.setMask))); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.clrMask) |=> ((stateChg & $past(strb.clrMask)) == '0)); // R7
  AST_UNTOUCHED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((stateChg ^ $past(stateChg)) & ~$past(strb.setMask) & ~$past(strb.clrMask)) == '0)); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strb.globalEn)); // R5
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(intSts[LOW_W-1:0] & sourceEn) != '0)); // R5
endmodule

// File: rtl/audio_irq_agg.sv
module audio_irq_agg
  import audio_irq_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STREAMS-1:0] streamDone,
  input  logic                   respIntFlag,
  input  logic                   respOverrun,
  input  logic [CODEC_CNT-1:0]   codecWake,
  input  logic [CODEC_CNT-1:0]   wakeEnable,
  input  logic                   stsWrEn,
  input  logic [CODEC_CNT-1:0]   stsWrData,
  input  logic [STS_W-1:0]       intCtl,
  output logic [CODEC_CNT-1:0]   stateChg,
  output logic [STS_W-1:0]       intSts,
  output logic                   irq
);
  irqStrobes_t strb;

  audio_irq_ctrl u_ctrl (
    .codecWake  (codecWake),
    .stsWrEn    (stsWrEn),
    .stsWrData  (stsWrData),
    .globalEnIn (intCtl[GLOBAL_BIT]),
    .strb       (strb)
  );

  audio_irq_datapath #(.NUM_STREAMS(NUM_STREAMS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .streamDone  (streamDone),
    .respIntFlag (respIntFlag),
    .respOverrun (respOverrun),
    .wakeEnable  (wakeEnable),
    .sourceEn    (intCtl[STS_W-2:0]),
    .stateChg    (stateChg),
    .intSts      (intSts),
    .irq         (irq)
  );
endmodule

// File: tb/audio_irq_agg_tb.sv
module audio_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  streamDone = '0;
  logic        respIntFlag = 1'b0;
  logic        respOverrun = 1'b0;
  logic [14:0] codecWake = '0;
  logic [14:0] wakeEnable = '0;
  logic        stsWrEn = 1'b0;
  logic [14:0] stsWrData = '0;
  logic [31:0] intCtl = '0;
  logic [14:0] stateChg;
  logic [31:0] intSts;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [14:0] mState = '0;
  logic        mIrq = 1'b0;

  always #5 clk = ~clk;

  audio_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .streamDone(streamDone), .respIntFlag(respIntFlag),
    .respOverrun(respOverrun), .codecWake(codecWake), .wakeEnable(wakeEnable),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .intCtl(intCtl),
    .stateChg(stateChg), .intSts(intSts), .irq(irq)
  );

  function automatic logic [31:0] calcSts(input logic [14:0] st);
    logic [31:0] s;
    s = '0;
    s[7:0] = streamDone;                                        // R1
    s[30]  = respIntFlag | respOverrun | (|(st & wakeEnable));  // R2 R3
    s[31]  = |s[30:0];                                          // R4
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [31:0] e;
    e = calcSts(mState);
    chk("R1 stream bits", {24'd0, intSts[7:0]}, {24'd0, e[7:0]});
    chk("R2 R3 controller bit", {31'd0, intSts[30]}, {31'd0, e[30]});
    chk("R4 summary bit", {31'd0, intSts[31]}, {31'd0, e[31]});
    chk("R10 reserved bits", {10'd0, intSts[29:8]}, 32'd0);
    chk("R5 irq line", {31'd0, irq}, {31'd0, mIrq});
    chk("R6 R7 R8 state reg", {17'd0, stateChg}, {17'd0, mState});
  endtask

  // inputs already applied at negedge; check, then advance one edge
  task automatic step();
    logic [31:0] e;
    #1 checkAll();
    e = calcSts(mState);
    @(posedge clk);
    mIrq   = intCtl[31] & (|(e[30:0] & intCtl[30:0]));
    mState = (mState & ~(stsWrEn ? stsWrData : 15'd0)) | codecWake;
    @(negedge clk);
  endtask

  task automatic setIn(input logic [7:0] sd, input logic ri, input logic ro,
                       input logic [14:0] cw, input logic [14:0] we,
                       input logic wr, input logic [14:0] wd, input logic [31:0] ctl);
    streamDone = sd; respIntFlag = ri; respOverrun = ro; codecWake = cw;
    wakeEnable = we; stsWrEn = wr; stsWrData = wd; intCtl = ctl;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    // R9: reset holds outputs low even with active inputs
    setIn(8'hff, 1'b1, 1'b1, 15'h7fff, 15'h7fff, 1'b0, 15'd0, 32'hffff_ffff);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq in reset", {31'd0, irq}, 32'd0);
    chk("R9 state in reset", {17'd0, stateChg}, 32'd0);
    @(negedge clk);
    setIn(8'h00, 1'b0, 1'b0, 15'd0, 15'd0, 1'b0, 15'd0, 32'd0);
    rstN = 1'b1;
    step();

    // R3: state bit set but not wake-enabled -> controller bit stays 0
    setIn(8'h00, 1'b0, 1'b0, 15'h0010, 15'h0000, 1'b0, 15'd0, 32'hc000_0000);
    step();
    setIn(8'h00, 1'b0, 1'b0, 15'h0000, 15'h7fef, 1'b0, 15'd0, 32'hc000_0000);
    step();
    setIn(8'h00, 1'b0, 1'b0, 15'h0000, 15'h0010, 1'b0, 15'd0, 32'hc000_0000);
    step();
    step();
    // R8: clear bit 4 and wake bit 4 in the same cycle; also clear bit 2 alone
    setIn(8'h00, 1'b0, 1'b0, 15'h0004, 15'h0010, 1'b0, 15'd0, 32'hc000_0000);
    step();
    setIn(8'h00, 1'b0, 1'b0, 15'h0010, 15'h0010, 1'b1, 15'h0014, 32'hc000_0000);
    step();
    // R7: write of zeros leaves the register unchanged
    setIn(8'h00, 1'b0, 1'b0, 15'h0000, 15'h0010, 1'b1, 15'h0000, 32'hc000_0000);
    step();
    setIn(8'h00, 1'b0, 1'b0, 15'h0000, 15'h0010, 1'b1, 15'h0010, 32'hc000_0000);
    step();
    // R5: global enable off with sources present -> irq low
    setIn(8'h5a, 1'b1, 1'b0, 15'd0, 15'd0, 1'b0, 15'd0, 32'h7fff_ffff);
    step();
    // R5: only global bits enabled, summary must not raise irq
    setIn(8'h5a, 1'b0, 1'b1, 15'd0, 15'd0, 1'b0, 15'd0, 32'h8000_0000);
    step();
    // R5: one matching stream enable raises irq
    setIn(8'h08, 1'b0, 1'b0, 15'd0, 15'd0, 1'b0, 15'd0, 32'h8000_0008);
    step();
    step();

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ctl;
      ctl = $urandom;
      if (n % 3 == 0) ctl[31] = 1'b1;
      setIn(8'($urandom & $urandom), 1'($urandom % 5 == 0), 1'($urandom % 7 == 0),
            15'($urandom & $urandom & $urandom), 15'($urandom),
            1'($urandom % 3 == 0), 15'($urandom), ctl);
      step();
    end

    // R9: mid-run reset clears state and drops irq
    setIn(8'hff, 1'b1, 1'b0, 15'h7fff, 15'h7fff, 1'b0, 15'd0, 32'hffff_ffff);
    step();
    rstN = 1'b0;
    #1;
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    chk("R9 state after reset", {17'd0, stateChg}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule